// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block lets an on-chip requester reach an external memory or peripheral over a shared 16-bit address/data bus. Each internal request carries a 24-bit address, a direction and write data. The controller turns it into a bus cycle. The address goes onto the shared lines under an address-latch strobe, so that an external latch can keep it. The bus then changes to data, and an active-low read or write strobe is pulsed. The pad tri-state is split into a drive value, a per-line output enable and a sampled input.

Two widths are supported. In wide mode, every cycle latches address bits 15..0 and then moves 16 data bits. In narrow mode, the external latch holds address bits 23..8. The controller remembers the last value it latched and leaves out the latch phase when the next access has the same upper bits. During the data phase, address bits 7..0 ride on the top byte lane and the data uses the bottom lane. The polarity of the latch strobe can be selected. A flag setting hands the lines to general-purpose use and keeps every strobe quiet. The latch, address-hold, data-setup and strobe phases each have a programmable length.

Top module: `mpbus_ctrl`

## Requirements
- R1: During and after reset, `ad_oe` is all zero, `rd_n` and `wr_n` are 1, `ale` is at its inactive level and `req_ready` is 0.
- R2: A wide-mode (`cfg_wide`=1) write drives address bits 15..0 on all lanes with the latch strobe active. It then keeps that address for the hold phase with the strobe inactive. After that it drives the write data on all 16 lanes through setup and the `wr_n` low phase.
- R3: A wide-mode read has the same address phases. It then releases all lanes, pulls `rd_n` low, and returns the 16 bits present on `ad_in` at the clock edge where `rd_n` rises. That value is on `rsp_rdata` while `req_ready` is high.
- R4: In narrow mode (`cfg_wide`=0), address bits 23..8 are driven with the latch strobe active. This happens only when those bits differ from the last latched value, or when no value is stored. Otherwise the access starts directly with the data phase. Whenever the latch strobe is active, all 16 lanes are driven.
- R5: In the narrow data phase, address bits 7..0 are driven on lanes 15..8. A write drives its data byte 7..0 on lanes 7..0. A read leaves lanes 7..0 released, and `rsp_rdata` is `ad_in[7:0]` with the upper 8 bits zero.
- R6: With `cfg_ale_low`=0, the latch strobe is active high. With `cfg_ale_low`=1, `ale` is inverted, so it idles at 1 and is 0 while active.
- R7: The latch, address-hold, data-setup and strobe phases last `cfg_ale_cyc`, `cfg_hold_cyc`, `cfg_setup_cyc` and `cfg_strobe_cyc` clock cycles. A programmed value of 0 counts as 1.
- R8: `req_ready` is high for exactly one cycle, the cycle right after the last strobe-low cycle. The bus is then idle.
- R9: While `cfg_flag`=1, no request is accepted. `rd_n`, `wr_n` and `ale` stay inactive, `ad_oe` stays zero and `req_ready` stays 0.
- R10: The stored upper-address value is discarded by reset and by any change of `cfg_wide` or `cfg_flag`. The next narrow access therefore runs a latch phase.
- R11: `rd_n` is low only for reads and `wr_n` only for writes. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit data mode, 0 = 8-bit data mode |
| cfg_ale_low | input | 1 | 1 = latch strobe active low |
| cfg_flag | input | 1 | 1 = lines in flag use, no bus cycles |
| cfg_ale_cyc | input | 4 | Latch-strobe phase length in cycles |
| cfg_hold_cyc | input | 4 | Address-hold phase length in cycles |
| cfg_setup_cyc | input | 4 | Data-setup phase length in cycles |
| cfg_strobe_cyc | input | 4 | Read/write strobe width in cycles |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 16 | Per-line output enable |
| ad_in | input | 16 | Value sampled from the shared lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach from the ports is the skipped latch phase. It needs a narrow access whose upper address matches a value that is still stored, with no reset or mode toggle since that value was latched. The stimulus sets up these histories on purpose. It sends back-to-back narrow accesses that share the upper bits. It toggles width and then flag use between two accesses to the same upper address, and it applies a reset in the middle of a run. A bench model follows the stored value and the expected strobe trace cycle by cycle. It is compared with every output on every clock, and counts of latch cycles per access confirm each hit or miss.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ALE    = 3'd1,
      PH_AHOLD  = 3'd2,
      PH_SETUP  = 3'd3,
      PH_STROBE = 3'd4,
      PH_DONE   = 3'd5
   } phase_e;

endpackage

// File: rtl/mpbus_phase_timer.sv
module mpbus_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expired
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("mpbus_phase_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] remain;

   // a programmed length of zero behaves as one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= (len == '0) ? '0 : len - 1'b1;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign expired = (remain == '0);

endmodule

// File: rtl/mpbus_tag_cache.sv
module mpbus_tag_cache #(
   parameter int UP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_wide,
   input  logic            mode_flag,
   input  logic [UP_W-1:0] upper,
   input  logic            load,
   output logic            hit
);

   logic            tag_vld;
   logic [UP_W-1:0] tag_q;
   logic            prev_wide;
   logic            prev_flag;
   logic            mode_changed;

   assign mode_changed = (mode_wide != prev_wide) || (mode_flag != prev_flag);
   assign hit          = tag_vld && (tag_q == upper) && !mode_changed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_vld   <= 1'b0;
         tag_q     <= '0;
         prev_wide <= 1'b0;
         prev_flag <= 1'b0;
      end else begin
         prev_wide <= mode_wide;
         prev_flag <= mode_flag;
         if (load) begin
            tag_q   <= upper;
            tag_vld <= 1'b1;
         end else if (mode_changed) begin
            tag_vld <= 1'b0;
         end
      end
   end

   AST_MODE_INVALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_changed && !load) |=> !tag_vld); // R10

endmodule

// File: rtl/mpbus_seq.sv
module mpbus_seq
   import mpbus_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             cfg_flag,
   input  logic             cfg_wide,
   input  logic             upper_hit,
   input  logic             expired,
   input  logic [CNT_W-1:0] ale_len,
   input  logic [CNT_W-1:0] hold_len,
   input  logic [CNT_W-1:0] setup_len,
   input  logic [CNT_W-1:0] strobe_len,
   output phase_e           phase,
   output logic             accept,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_len,
   output logic             capture
);

   phase_e nxt;

   assign accept  = (phase == PH_IDLE) && req_valid && !cfg_flag;
   assign capture = (phase == PH_STROBE) && expired;

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE:   if (accept) nxt = (cfg_wide || !upper_hit) ? PH_ALE : PH_SETUP;
         PH_ALE:    if (expired) nxt = PH_AHOLD;
         PH_AHOLD:  if (expired) nxt = PH_SETUP;
         PH_SETUP:  if (expired) nxt = PH_STROBE;
         PH_STROBE: if (expired) nxt = PH_DONE;
         PH_DONE:   nxt = PH_IDLE;
         default:   nxt = PH_IDLE;
      endcase
   end

   // each phase timer is reloaded on entry to the phase
   assign timer_load = (nxt != phase);

   always_comb begin
      unique case (nxt)
         PH_ALE:    timer_len = ale_len;
         PH_AHOLD:  timer_len = hold_len;
         PH_SETUP:  timer_len = setup_len;
         PH_STROBE: timer_len = strobe_len;
         default:   timer_len = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt;
   end

   AST_FLAG_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flag && phase == PH_IDLE) |=> (phase == PH_IDLE)); // R9

   AST_SKIP_ONLY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && $past(phase) == PH_IDLE) ##1 (phase == PH_SETUP) |-> !$past(cfg_wide)); // R4

endmodule

// File: rtl/mpbus_pad_drive.sv
module mpbus_pad_drive
   import mpbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int BUS_W  = 16
) (
   input  phase_e            phase,
   input  logic              r_write,
   input  logic              r_wide,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [BUS_W-1:0]  r_wdata,
   input  logic              cfg_ale_low,
   output logic [BUS_W-1:0]  ad_out,
   output logic [BUS_W-1:0]  ad_oe,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n
);

   localparam int LANES = BUS_W / 8;

   logic             addr_ph;
   logic             data_ph;
   logic [BUS_W-1:0] addr_word;

   assign addr_ph   = (phase == PH_ALE) || (phase == PH_AHOLD);
   assign data_ph   = (phase == PH_SETUP) || (phase == PH_STROBE);
   assign addr_word = r_wide ? r_addr[BUS_W-1:0] : r_addr[ADDR_W-1:8];

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         logic [7:0] data_byte;
         logic       data_en;
         if (j == 0) begin : g_low
            // lowest lane always carries data in both widths
            assign data_byte = r_wdata[7:0];
            assign data_en   = r_write;
         end else begin : g_high
            // upper lanes carry data when wide, low address bits when narrow
            assign data_byte = r_wide ? r_wdata[8*j+7 -: 8] : r_addr[8*j-1 -: 8];
            assign data_en   = r_wide ? r_write : 1'b1;
         end
         always_comb begin
            if (addr_ph) begin
               ad_out[8*j+7 -: 8] = addr_word[8*j+7 -: 8];
               ad_oe[8*j+7 -: 8]  = 8'hFF;
            end else if (data_ph) begin
               ad_out[8*j+7 -: 8] = data_byte;
               ad_oe[8*j+7 -: 8]  = {8{data_en}};
            end else begin
               ad_out[8*j+7 -: 8] = 8'h00;
               ad_oe[8*j+7 -: 8]  = 8'h00;
            end
         end
      end
   endgenerate

   assign ale  = (phase == PH_ALE) ^ cfg_ale_low;
   assign rd_n = !((phase == PH_STROBE) && !r_write);
   assign wr_n = !((phase == PH_STROBE) && r_write);

endmodule

// File: rtl/mpbus_ctrl.sv
module mpbus_ctrl
   import mpbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int BUS_W  = 16,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic              cfg_ale_low,
   input  logic              cfg_flag,
   input  logic [CNT_W-1:0]  cfg_ale_cyc,
   input  logic [CNT_W-1:0]  cfg_hold_cyc,
   input  logic [CNT_W-1:0]  cfg_setup_cyc,
   input  logic [CNT_W-1:0]  cfg_strobe_cyc,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   output logic              req_ready,
   output logic [BUS_W-1:0]  rsp_rdata,
   output logic [BUS_W-1:0]  ad_out,
   output logic [BUS_W-1:0]  ad_oe,
   input  logic [BUS_W-1:0]  ad_in,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n
);

   localparam int UP_W = ADDR_W - 8;

   generate
      if (BUS_W % 8 != 0 || BUS_W < 16) begin : g_bad_bus
         $error("mpbus_ctrl: BUS_W must be a multiple of 8 and at least 16");
      end
      if (UP_W != BUS_W) begin : g_bad_addr
         $error("mpbus_ctrl: ADDR_W must equal BUS_W + 8");
      end
   endgenerate

   phase_e            phase;
   logic              accept;
   logic              timer_load;
   logic [CNT_W-1:0]  timer_len;
   logic              expired;
   logic              capture;
   logic              upper_hit;
   logic              tag_load;
   logic              r_write;
   logic              r_wide;
   logic [ADDR_W-1:0] r_addr;
   logic [BUS_W-1:0]  r_wdata;
   logic [BUS_W-1:0]  rdata_q;

   assign tag_load = accept && !cfg_wide && !upper_hit;

   mpbus_tag_cache #(.UP_W(UP_W)) u_tag (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wide (cfg_wide),
      .mode_flag (cfg_flag),
      .upper     (req_addr[ADDR_W-1:8]),
      .load      (tag_load),
      .hit       (upper_hit)
   );

   mpbus_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .cfg_flag   (cfg_flag),
      .cfg_wide   (cfg_wide),
      .upper_hit  (upper_hit),
      .expired    (expired),
      .ale_len    (cfg_ale_cyc),
      .hold_len   (cfg_hold_cyc),
      .setup_len  (cfg_setup_cyc),
      .strobe_len (cfg_strobe_cyc),
      .phase      (phase),
      .accept     (accept),
      .timer_load (timer_load),
      .timer_len  (timer_len),
      .capture    (capture)
   );

   mpbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (timer_load),
      .len     (timer_len),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_write <= 1'b0;
         r_wide  <= 1'b0;
         r_addr  <= '0;
         r_wdata <= '0;
      end else if (accept) begin
         r_write <= req_write;
         r_wide  <= cfg_wide;
         r_addr  <= req_addr;
         r_wdata <= req_wdata;
      end
   end

   // read data is taken on the edge where the read strobe returns high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture && !r_write) begin
         rdata_q <= r_wide ? ad_in : {{(BUS_W-8){1'b0}}, ad_in[7:0]};
      end
   end

   assign rsp_rdata = rdata_q;
   assign req_ready = (phase == PH_DONE);

   mpbus_pad_drive #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_pad (
      .phase       (phase),
      .r_write     (r_write),
      .r_wide      (r_wide),
      .r_addr      (r_addr),
      .r_wdata     (r_wdata),
      .cfg_ale_low (cfg_ale_low),
      .ad_out      (ad_out),
      .ad_oe       (ad_oe),
      .ale         (ale),
      .rd_n        (rd_n),
      .wr_n        (wr_n)
   );

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready); // R8

   AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !$past(rd_n && wr_n)); // R8

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> wr_n); // R11

   AST_ALE_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ale != cfg_ale_low) |-> (ad_oe == {BUS_W{1'b1}})); // R4

   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flag && $past(cfg_flag) && $past(phase == PH_IDLE)) |-> (rd_n && wr_n && ad_oe == '0)); // R9

endmodule

// File: tb/mpbus_ctrl_test.sv
module mpbus_ctrl_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wide = 1'b1;
   logic        cfg_ale_low = 1'b0;
   logic        cfg_flag = 1'b0;
   logic [3:0]  cfg_ale_cyc = 4'd1;
   logic [3:0]  cfg_hold_cyc = 4'd1;
   logic [3:0]  cfg_setup_cyc = 4'd1;
   logic [3:0]  cfg_strobe_cyc = 4'd1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] rsp_rdata;
   logic [15:0] ad_out;
   logic [15:0] ad_oe;
   logic [15:0] ad_in = '0;
   logic        ale;
   logic        rd_n;
   logic        wr_n;

   int checks = 0;
   int fails = 0;
   bit run = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   mpbus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_ale_low(cfg_ale_low),
      .cfg_flag(cfg_flag), .cfg_ale_cyc(cfg_ale_cyc), .cfg_hold_cyc(cfg_hold_cyc),
      .cfg_setup_cyc(cfg_setup_cyc), .cfg_strobe_cyc(cfg_strobe_cyc),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int eff(input logic [3:0] n);
      return (n == 0) ? 1 : int'(n);
   endfunction

   // ---------------- behavioural reference model ----------------
   typedef struct {
      bit          idl;
      bit          ale_act;
      bit          rdn;
      bit          wrn;
      logic [15:0] oe;
      logic [15:0] ad;
      bit          rdy;
      bit          chk_rd;
      logic [15:0] rd;
      int          tag;
   } ent_t;

   ent_t        q[$];
   ent_t        cur;
   bit          m_vld;
   logic [15:0] m_tag;
   bit          m_pw;
   bit          m_pf;

   function automatic ent_t idle_ent();
      ent_t e;
      e.idl = 1; e.ale_act = 0; e.rdn = 1; e.wrn = 1; e.oe = '0; e.ad = '0;
      e.rdy = 0; e.chk_rd = 0; e.rd = '0;
      e.tag = cfg_flag ? 9 : 8; // R9 when flagged, otherwise R8 (idle after ready)
      return e;
   endfunction

   task automatic push_access();
      ent_t        e;
      bit          do_ale;
      logic [15:0] aw;
      int          atag;
      int          dtag;
      do_ale = cfg_wide || !(m_vld && m_tag == req_addr[23:8]);
      aw     = cfg_wide ? req_addr[15:0] : req_addr[23:8];
      atag   = cfg_ale_low ? 6 : (cfg_wide ? 2 : 4);      // R2 R4 R6
      dtag   = cfg_wide ? (req_write ? 2 : 3) : 5;         // R2 R3 R5
      if (!cfg_wide && do_ale) begin m_vld = 1; m_tag = req_addr[23:8]; end
      e = idle_ent();
      e.idl = 0;
      if (do_ale) begin
         for (int i = 0; i < eff(cfg_ale_cyc); i++) begin
            e.ale_act = 1; e.oe = 16'hFFFF; e.ad = aw; e.tag = atag; q.push_back(e);
         end
         for (int i = 0; i < eff(cfg_hold_cyc); i++) begin
            e.ale_act = 0; e.oe = 16'hFFFF; e.ad = aw; e.tag = atag; q.push_back(e);
         end
      end
      e.ale_act = 0;
      e.tag     = dtag;
      if (cfg_wide) begin
         e.oe = req_write ? 16'hFFFF : 16'h0000;
         e.ad = req_wdata;
      end else begin
         e.oe = req_write ? 16'hFFFF : 16'hFF00;
         e.ad = {req_addr[7:0], req_wdata[7:0]};
      end
      for (int i = 0; i < eff(cfg_setup_cyc); i++) q.push_back(e);
      e.rdn = req_write;
      e.wrn = !req_write;
      for (int i = 0; i < eff(cfg_strobe_cyc); i++) q.push_back(e);
      e = idle_ent();
      e.idl    = 0;
      e.rdy    = 1;
      e.chk_rd = !req_write;
      e.rd     = cfg_wide ? ad_in : {8'h00, ad_in[7:0]};
      e.tag    = 8;
      q.push_back(e);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         cur   = idle_ent();
         m_vld = 0; m_tag = '0; m_pw = 0; m_pf = 0;   // R10: reset forgets the upper bits
      end else begin
         if (cfg_wide != m_pw || cfg_flag != m_pf) m_vld = 0; // R10
         m_pw = cfg_wide;
         m_pf = cfg_flag;
         if (q.size() > 0) cur = q.pop_front();
         else if (cur.idl && req_valid && !cfg_flag) begin
            push_access();
            cur = q.pop_front();
         end else cur = idle_ent();
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && run) begin
         bit ok;
         ok = (ale == (cur.ale_act ^ cfg_ale_low)) && (rd_n == cur.rdn) && (wr_n == cur.wrn) &&
              (ad_oe == cur.oe) && ((ad_out & cur.oe) == (cur.ad & cur.oe)) &&
              (req_ready == cur.rdy) && (!cur.chk_rd || rsp_rdata == cur.rd);
         checks++;
         if (!ok) begin
            fails++;
            $display("FAIL R%0d trace: actual ale=%b rd_n=%b wr_n=%b oe=%h ad=%h rdy=%b rd=%h expected ale=%b rd_n=%b wr_n=%b oe=%h ad=%h rdy=%b rd=%h at %0t",
                     cur.tag, ale, rd_n, wr_n, ad_oe, ad_out & ad_oe, req_ready, rsp_rdata,
                     cur.ale_act ^ cfg_ale_low, cur.rdn, cur.wrn, cur.oe, cur.ad & cur.oe,
                     cur.rdy, cur.rd, $time);
         end
         chk(rd_n || wr_n, "R11", {rd_n, wr_n}, 2'b11);
      end
   end

   // ---------------- stimulus ----------------
   task automatic access(input bit w, input logic [23:0] a, input logic [15:0] d,
                         input logic [15:0] rin, output int nale, output int nstb,
                         output logic [15:0] rdat);
      int guard;
      @(negedge clk);
      ad_in = rin; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      nale = 0; nstb = 0; guard = 0;
      do begin
         @(negedge clk);
         if (ale !== cfg_ale_low) nale++;
         if (!rd_n || !wr_n) nstb++;
         guard++;
      end while (!req_ready && guard < 200);
      rdat = rsp_rdata;
      req_valid = 1'b0;
      if (guard >= 200) chk(1'b0, "R8", 0, 1);
      @(negedge clk);
      chk(req_ready == 1'b0, "R8", req_ready, 0);  // R8 single-cycle pulse
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(ad_oe == 16'h0, "R1", ad_oe, 0);
      chk(rd_n && wr_n, "R1", {rd_n, wr_n}, 2'b11);
      chk(ale == cfg_ale_low, "R1", ale, cfg_ale_low);
      chk(req_ready == 1'b0, "R1", req_ready, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int          na;
      int          ns;
      logic [15:0] rd;

      do_reset();   // R1
      run = 1'b1;

      // R2: wide write
      cfg_wide = 1; cfg_ale_cyc = 1; cfg_hold_cyc = 1; cfg_setup_cyc = 1; cfg_strobe_cyc = 2;
      access(1, 24'h123456, 16'hA5C3, 16'h0000, na, ns, rd);
      chk(na == 1, "R2", na, 1);
      chk(ns == 2, "R7", ns, 2);

      // R3: wide read
      access(0, 24'h00ABCD, 16'h0000, 16'h5A71, na, ns, rd);
      chk(rd == 16'h5A71, "R3", rd, 16'h5A71);

      // R7: zero lengths behave as one
      cfg_ale_cyc = 0; cfg_hold_cyc = 0; cfg_setup_cyc = 0; cfg_strobe_cyc = 0;
      access(0, 24'h000F0F, 16'h0000, 16'h1234, na, ns, rd);
      chk(na == 1 && ns == 1, "R7", {na[7:0], ns[7:0]}, 16'h0101);
      cfg_ale_cyc = 3; cfg_hold_cyc = 2; cfg_setup_cyc = 2; cfg_strobe_cyc = 4;
      access(1, 24'h00C0DE, 16'hFACE, 16'h0000, na, ns, rd);
      chk(na == 3 && ns == 4, "R7", {na[7:0], ns[7:0]}, 16'h0304);

      // R4 / R5: narrow mode, miss then hit
      cfg_wide = 0; cfg_ale_cyc = 2; cfg_hold_cyc = 1; cfg_setup_cyc = 1; cfg_strobe_cyc = 2;
      access(1, 24'h778899, 16'h00E1, 16'h0000, na, ns, rd);
      chk(na == 2, "R4", na, 2);
      access(1, 24'h778811, 16'h0042, 16'h0000, na, ns, rd);
      chk(na == 0, "R4", na, 0);
      access(0, 24'h778822, 16'h0000, 16'hBEEF, na, ns, rd);
      chk(na == 0, "R4", na, 0);
      chk(rd == 16'h00EF, "R5", rd, 16'h00EF);
      access(0, 24'h112233, 16'h0000, 16'h3C96, na, ns, rd);
      chk(na == 2, "R4", na, 2);
      chk(rd == 16'h0096, "R5", rd, 16'h0096);

      // R10: width toggle discards the stored upper bits
      @(negedge clk); cfg_wide = 1;
      repeat (2) @(negedge clk); cfg_wide = 0;
      access(1, 24'h112244, 16'h0011, 16'h0000, na, ns, rd);
      chk(na == 2, "R10", na, 2);
      // R10: flag toggle also discards it
      @(negedge clk); cfg_flag = 1;
      repeat (2) @(negedge clk); cfg_flag = 0;
      access(1, 24'h112255, 16'h0022, 16'h0000, na, ns, rd);
      chk(na == 2, "R10", na, 2);
      // R10: reset discards it
      do_reset();
      access(1, 24'h112266, 16'h0033, 16'h0000, na, ns, rd);
      chk(na == 2, "R10", na, 2);

      // R6: active-low latch strobe
      @(negedge clk); cfg_ale_low = 1; cfg_wide = 1;
      @(negedge clk);
      chk(ale == 1'b1, "R6", ale, 1);
      access(1, 24'h00BEEF, 16'h1357, 16'h0000, na, ns, rd);
      chk(na == 2, "R6", na, 2);
      @(negedge clk); cfg_ale_low = 0;

      // R9: flag use blocks every request
      @(negedge clk); cfg_flag = 1; cfg_wide = 0;
      @(negedge clk); req_valid = 1; req_write = 1; req_addr = 24'h445566;
      begin
         int seen;
         seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_ready || !rd_n || !wr_n || ad_oe != 0 || ale != cfg_ale_low) seen++;
         end
         chk(seen == 0, "R9", seen, 0);
      end
      req_valid = 0;
      @(negedge clk); cfg_flag = 0;
      access(0, 24'h445566, 16'h0000, 16'h0077, na, ns, rd);
      chk(na == 2 && rd == 16'h0077, "R9", {na[7:0], rd}, 24'h020077);

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule